// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block picks which of four clock sources drives the system clock: a multi-speed internal oscillator, a high-speed internal oscillator, an external oscillator, or the PLL output. Software writes a 2-bit request into the select field. The block moves the active selection to that source only once the source reports ready. It reports the source in use through a status code and a byte-aligned status readout. The active selection is a registered code that a downstream glitch-free multiplexer consumes.

Two events force the selection back to the multi-speed internal oscillator:

- a wakeup from a low-power mode;
- a detected external-clock failure while clock security is enabled. This applies when the external clock is in use directly, or when the PLL is in use and fed from the external clock.

A forced fallback also rewrites the select field, so the failed source is not picked up again on its own.

Top module: `sysclk_switch`

## Requirements
- R1: After reset, both the select field (`sel_o`) and the active code (`stat_o`) are 0, meaning the multi-speed internal source. Source codes are: 0 = multi-speed internal, 1 = high-speed internal, 2 = external, 3 = PLL.
- R2: `stat_byte_o` always equals the active code shifted left by two, with every other bit zero. The readout is therefore 0x00, 0x04, 0x08 or 0x0C.
- R3: If the requested source is ready, the active code takes the requested code on the first clock edge after the edge that stored the request.
- R4: While the requested source is not ready, the active code holds. It moves to the request on the first edge at which that source's ready bit is high.
- R5: A new write replaces a pending request. A source that was requested earlier and later becomes ready is not selected.
- R6: The active code never changes on the edge at which a select write is taken.
- R7: With security enabled, an external-clock failure while the external source is active forces both the active code and the select field to 0 on the next edge.
- R8: With security enabled, a failure while the PLL is active forces the same fallback only if the PLL input is the external clock (`pll_src_ext_i` = 1). If the PLL runs from an internal input, the failure has no effect.
- R9: With the security enable clear, the failure input is ignored.
- R10: A wakeup pulse forces both the active code and the select field to 0 on the next edge, whatever is requested or active.
- R11: After a forced fallback, the block stays on the internal source even when the failed source reports ready, until software writes a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_wr_i | input | 1 | Write strobe for the select field |
| sel_wdata_i | input | 2 | Requested source code |
| rdy_i | input | 4 | Ready flag per source, indexed by code |
| css_en_i | input | 1 | Clock security enable |
| ext_fail_i | input | 1 | External-clock failure detect |
| pll_src_ext_i | input | 1 | PLL input is the external clock |
| wake_i | input | 1 | Wakeup from low-power mode |
| sel_o | output | 2 | Select field readback |
| stat_o | output | 2 | Active source code |
| stat_byte_o | output | 8 | Active code as a byte readout, code in bits [3:2] |

## Verification
The switch is tried in three ways:

- A request to a source that is already ready. This separates the write edge from the switch edge.
- A request to a source that is not yet ready and becomes ready cycles later. This shows the deferral.
- A request overwritten before its source is ready. This shows that only the latest request is honoured.

Failure pulses are applied with the external source active, with the PLL active on each of its two inputs, and with security disabled. Together these show that the fallback fires only when the failed clock actually feeds the system. A wakeup pulse and a ready external source after a fallback confirm that the forced selection sticks.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int unsigned NSRC  = 4;
  localparam int unsigned SEL_W = $clog2(NSRC);

  typedef enum logic [SEL_W-1:0] {
    SRC_MSI = 2'd0,
    SRC_HSI = 2'd1,
    SRC_EXT = 2'd2,
    SRC_PLL = 2'd3
  } src_e;
endpackage

// File: rtl/sysclk_sel_reg.sv
module sysclk_sel_reg
  import sysclk_pkg::*;
#(
  parameter int unsigned W        = SEL_W,
  parameter logic [W-1:0] FALLBACK = SRC_MSI
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         force_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] sel_o
);
  logic [W-1:0] sel_q;

  // force outranks software so a failed source is never re-requested
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= FALLBACK;
    else if (force_i) sel_q <= FALLBACK;
    else if (wr_i)    sel_q <= wdata_i;
  end

  assign sel_o = sel_q;

  a_r5_write_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !force_i) |=> (sel_q == $past(wdata_i)));
  a_r11_force_clears_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> (sel_q == FALLBACK));
endmodule

// File: rtl/sysclk_guard.sv
module sysclk_guard
  import sysclk_pkg::*;
#(
  parameter int unsigned W = SEL_W
) (
  input  logic [W-1:0] act_i,
  input  logic         css_en_i,
  input  logic         ext_fail_i,
  input  logic         pll_src_ext_i,
  input  logic         wake_i,
  output logic         force_o
);
  logic ext_in_use;
  logic fail_hit;

  always_comb begin
    ext_in_use = (act_i == SRC_EXT) || ((act_i == SRC_PLL) && pll_src_ext_i);
    fail_hit   = css_en_i && ext_fail_i && ext_in_use;
    force_o    = wake_i || fail_hit;
  end
endmodule

// File: rtl/sysclk_active_reg.sv
module sysclk_active_reg
  import sysclk_pkg::*;
#(
  parameter int unsigned N        = NSRC,
  parameter int unsigned W        = SEL_W,
  parameter logic [W-1:0] FALLBACK = SRC_MSI
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         force_i,
  input  logic         wr_i,
  input  logic [W-1:0] sel_i,
  input  logic [N-1:0] rdy_i,
  output logic [W-1:0] act_o
);
  logic [W-1:0] act_q;
  logic         tgt_rdy;
  logic         do_switch;

  always_comb begin
    tgt_rdy   = rdy_i[sel_i];
    // a write edge never switches: the old request is about to be replaced
    do_switch = !wr_i && tgt_rdy && (sel_i != act_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        act_q <= FALLBACK;
    else if (force_i)   act_q <= FALLBACK;
    else if (do_switch) act_q <= sel_i;
  end

  assign act_o = act_q;

  a_r3_switch_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_i && !wr_i && rdy_i[sel_i]) |=> (act_q == $past(sel_i)));
  a_r4_hold_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_i && !rdy_i[sel_i]) |=> $stable(act_q));
  a_r6_no_change_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !force_i) |=> $stable(act_q));
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
  import sysclk_pkg::*;
#(
  parameter int unsigned N        = NSRC,
  parameter int unsigned W        = SEL_W,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned STAT_LSB = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_wr_i,
  input  logic [W-1:0]      sel_wdata_i,
  input  logic [N-1:0]      rdy_i,
  input  logic              css_en_i,
  input  logic              ext_fail_i,
  input  logic              pll_src_ext_i,
  input  logic              wake_i,
  output logic [W-1:0]      sel_o,
  output logic [W-1:0]      stat_o,
  output logic [BYTE_W-1:0] stat_byte_o
);
  localparam int unsigned PAD_W = BYTE_W - W - STAT_LSB;
  localparam logic [W-1:0] FALLBACK = SRC_MSI;

  logic [W-1:0] sel;
  logic [W-1:0] act;
  logic         force_fb;

  sysclk_guard #(.W(W)) u_guard (
    .act_i        (act),
    .css_en_i     (css_en_i),
    .ext_fail_i   (ext_fail_i),
    .pll_src_ext_i(pll_src_ext_i),
    .wake_i       (wake_i),
    .force_o      (force_fb)
  );

  sysclk_sel_reg #(.W(W), .FALLBACK(FALLBACK)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .force_i(force_fb),
    .wr_i   (sel_wr_i),
    .wdata_i(sel_wdata_i),
    .sel_o  (sel)
  );

  sysclk_active_reg #(.N(N), .W(W), .FALLBACK(FALLBACK)) u_act (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .force_i(force_fb),
    .wr_i   (sel_wr_i),
    .sel_i  (sel),
    .rdy_i  (rdy_i),
    .act_o  (act)
  );

  assign sel_o       = sel;
  assign stat_o      = act;
  assign stat_byte_o = {{PAD_W{1'b0}}, act, {STAT_LSB{1'b0}}};

  a_r7_r8_fail_fallback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (css_en_i && ext_fail_i &&
     ((stat_o == SRC_EXT) || ((stat_o == SRC_PLL) && pll_src_ext_i)))
    |=> (stat_o == FALLBACK) && (sel_o == FALLBACK));
  a_r9_fail_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!css_en_i && !wake_i && !sel_wr_i && !rdy_i[sel_o]) |=> $stable(stat_o));
  a_r10_wake_default: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> (stat_o == FALLBACK) && (sel_o == FALLBACK));
endmodule

// File: tb/sysclk_switch_tb.sv
module sysclk_switch_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_wr = 1'b0;
  logic [1:0] sel_wdata = 2'd0;
  logic [3:0] rdy = 4'b0001;
  logic       css_en = 1'b0;
  logic       ext_fail = 1'b0;
  logic       pll_src_ext = 1'b0;
  logic       wake = 1'b0;
  logic [1:0] sel_o;
  logic [1:0] stat_o;
  logic [7:0] stat_byte;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sysclk_switch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_wr_i(sel_wr), .sel_wdata_i(sel_wdata),
    .rdy_i(rdy), .css_en_i(css_en), .ext_fail_i(ext_fail),
    .pll_src_ext_i(pll_src_ext), .wake_i(wake),
    .sel_o(sel_o), .stat_o(stat_o), .stat_byte_o(stat_byte)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance one edge, then settle past it
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_sel(input logic [1:0] code);
    @(negedge clk); sel_wr = 1'b1; sel_wdata = code;
    step();
    sel_wr = 1'b0;
  endtask

  task automatic fail_pulse();
    @(negedge clk); ext_fail = 1'b1;
    step();
    ext_fail = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 sel", sel_o, 0);
    chk("R1 stat", stat_o, 0);
    chk("R2 byte", stat_byte, 8'h00);
  endtask

  task automatic t_ready_switch();
    rdy = 4'b0011;
    wr_sel(2'd1);
    chk("R6 no switch on write edge", stat_o, 0);
    chk("R3 sel stored", sel_o, 1);
    step();
    chk("R3 switched", stat_o, 1);
    chk("R2 byte hsi", stat_byte, 8'h04);
  endtask

  task automatic t_deferred();
    wr_sel(2'd3);
    for (int i = 0; i < 5; i++) step();
    chk("R4 held pending", stat_o, 1);
    @(negedge clk); rdy[3] = 1'b1;
    step();
    chk("R4 switched on ready", stat_o, 3);
    chk("R2 byte pll", stat_byte, 8'h0C);
  endtask

  task automatic t_latest();
    rdy[2] = 1'b0;
    wr_sel(2'd2);
    step(); step();
    chk("R5 pending ext not taken", stat_o, 3);
    wr_sel(2'd0);
    chk("R6 no change on write", stat_o, 3);
    step();
    chk("R5 newest request", stat_o, 0);
    @(negedge clk); rdy[2] = 1'b1;
    step(); step(); step();
    chk("R5 stale request ignored", stat_o, 0);
  endtask

  task automatic t_fail_direct();
    css_en = 1'b1;
    wr_sel(2'd2);
    step();
    chk("R3 ext active", stat_o, 2);
    chk("R2 byte ext", stat_byte, 8'h08);
    fail_pulse();
    chk("R7 stat fallback", stat_o, 0);
    chk("R7 sel fallback", sel_o, 0);
    step(); step(); step();
    chk("R11 no reselect", stat_o, 0);
  endtask

  task automatic t_fail_pll();
    pll_src_ext = 1'b1;
    wr_sel(2'd3);
    step();
    chk("R8 pll active", stat_o, 3);
    fail_pulse();
    chk("R8 pll ext fallback", stat_o, 0);
    chk("R8 pll ext sel", sel_o, 0);
    @(negedge clk); pll_src_ext = 1'b0;
    wr_sel(2'd3);
    step();
    fail_pulse();
    chk("R8 pll internal kept", stat_o, 3);
    chk("R8 pll internal sel", sel_o, 3);
  endtask

  task automatic t_css_off();
    css_en = 1'b0;
    wr_sel(2'd2);
    step();
    fail_pulse();
    chk("R9 fail ignored stat", stat_o, 2);
    chk("R9 fail ignored sel", sel_o, 2);
  endtask

  task automatic t_wake();
    @(negedge clk); wake = 1'b1;
    step();
    wake = 1'b0;
    chk("R10 wake stat", stat_o, 0);
    chk("R10 wake sel", sel_o, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    #11 rst_n = 1'b1;
    step();
    t_reset();
    t_ready_switch();
    t_deferred();
    t_latest();
    t_fail_direct();
    t_fail_pll();
    t_css_off();
    t_wake();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule